// File: doc/BRIEF.md
# Capability load tag filter

This block sits at the writeback end of a capability-load pipeline. For each completed memory read it receives the loaded capability (its tag bit and data bits), the load-capability permission of the capability that authorised the access, any memory-access fault, and the load policy that each level of the address-translation walk attached to the page. It folds the per-level policies into one and applies the result to the loaded tag. From that it produces the register writeback value, a retire success or failure flag, an exception request with its cause code, and a strobe that sets the load reservation when the access came from a load-reserved operation.

The page policy has three legal values. Allow passes the tag through, gated by the authorising permission. Clear strips the tag. Trap faults only when the loaded tag is set; a capability with a clear tag under a trap page is written back untouched. One outcome is registered per accepted input, and results leave through a valid/ready handshake with a single output register.

Top module: `cap_load_tag_filter`

## Requirements
- R1: With the folded policy allow (code 2'b00) and no memory fault, the written tag equals the loaded tag AND the authorising load-capability permission, the data bits are written unchanged, and the load retires successfully.
- R2: With the folded policy clear (code 2'b01) and no memory fault, the capability is written with tag 0 and unchanged data bits, and the load retires successfully.
- R3: With the folded policy trap (code 2'b10) and a set loaded tag, the block raises an exception with cause LC_FAULT_CAUSE (default 27), performs no writeback and retires as failed.
- R4: With the folded policy trap and a clear loaded tag, the value is written unchanged (tag 0, same data) and the load retires successfully.
- R5: The reservation strobe is 1 exactly when the load-reserved input was set and the outcome retires successfully; it is never 1 when an exception is raised.
- R6: A memory-access fault overrides every policy: the exception is raised with the memory cause passed through, no writeback happens and the load retires as failed.
- R7: The walk policy is folded over the levels marked used, starting at allow, taking the maximum in the order allow < clear < trap; with no level used the result is allow.
- R8: The policy code 2'b11 on any used level is treated as trap.
- R9: An input accepted at a clock edge (in_valid and in_ready high) appears on the outputs with out_valid high after that edge; while out_valid is high and out_ready low the outputs hold; in_ready is high when the output register is empty or being drained.
- R10: After reset out_valid is 0 and in_ready is 1.
- R11: When no writeback is performed, out_wb_tag is 0 and out_wb_data is all zeros.

Top module ports below; LEVELS defaults to 3, DATA_W to 64, CAUSE_W to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input outcome available |
| in_ready | output | 1 | Block can take an input this cycle |
| in_tag | input | 1 | Tag bit of the loaded capability |
| in_data | input | DATA_W | Data bits of the loaded capability |
| in_perm_lc | input | 1 | Load-capability permission of the authorising capability |
| in_lr | input | 1 | Access is a load-reserved operation |
| in_mem_fault | input | 1 | Memory access faulted |
| in_mem_cause | input | CAUSE_W | Cause code of the memory fault |
| in_lvl_pol | input | 2*LEVELS | Per-level policy codes, level i at bits [2i+1:2i] |
| in_lvl_used | input | LEVELS | Level i of the walk took part |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_wb_en | output | 1 | Write the capability register |
| out_wb_tag | output | 1 | Tag to write |
| out_wb_data | output | DATA_W | Data bits to write |
| out_retire_ok | output | 1 | Load retires successfully |
| out_exc | output | 1 | Exception request |
| out_exc_cause | output | CAUSE_W | Exception cause code |
| out_resv_set | output | 1 | Set the load reservation |

## Verification
A wrongly folded walk policy shows up as the wrong outcome class on the very next result: a tag that survives where it should be stripped, or a fault where the capability should have been written. A broken output register shows at the ports within one cycle of back-pressure, as a result that changes or vanishes while out_ready is low, or as a result duplicated or dropped relative to the accepted inputs. The bench keeps an expected-result queue driven by a behavioural model and compares occupancy and contents on every clock.

// File: rtl/cap_ld_pkg.sv
package cap_ld_pkg;

    typedef enum logic [1:0] {
        POL_ALLOW = 2'b00,
        POL_CLEAR = 2'b01,
        POL_TRAP  = 2'b10,
        POL_BAD   = 2'b11
    } lc_pol_e;

    typedef enum logic [1:0] {
        OC_WRITE     = 2'b00,
        OC_LC_FAULT  = 2'b01,
        OC_MEM_FAULT = 2'b10
    } lc_outcome_e;

    // Map the illegal code onto the strictest legal policy.
    function automatic lc_pol_e pol_norm(input lc_pol_e p);
        return (p == POL_BAD) ? POL_TRAP : p;
    endfunction

    // Ordered join: the stricter of accumulator and new level wins.
    function automatic lc_pol_e pol_join(input lc_pol_e acc, input lc_pol_e lvl);
        lc_pol_e n;
        n = pol_norm(lvl);
        return (n > acc) ? n : acc;
    endfunction

endpackage

// File: rtl/cap_ld_pol_fold.sv
module cap_ld_pol_fold
    import cap_ld_pkg::*;
#(
    parameter int LEVELS = 3
) (
    input  logic [2*LEVELS-1:0] lvl_pol,
    input  logic [LEVELS-1:0]   lvl_used,
    output lc_pol_e             pol
);

    lc_pol_e acc [LEVELS+1];

    assign acc[0] = POL_ALLOW;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        lc_pol_e this_lvl;
        assign this_lvl   = lc_pol_e'(lvl_pol[2*g +: 2]);
        assign acc[g+1]   = lvl_used[g] ? pol_join(acc[g], this_lvl) : acc[g];
    end

    assign pol = acc[LEVELS];

endmodule

// File: rtl/cap_ld_decide.sv
module cap_ld_decide
    import cap_ld_pkg::*;
#(
    parameter int                DATA_W         = 64,
    parameter int                CAUSE_W        = 6,
    parameter logic [CAUSE_W-1:0] LC_FAULT_CAUSE = CAUSE_W'(27)
) (
    input  logic               tag,
    input  logic [DATA_W-1:0]  data,
    input  logic               perm_lc,
    input  logic               lr,
    input  logic               mem_fault,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  lc_pol_e            pol,
    output logic               wb_en,
    output logic               wb_tag,
    output logic [DATA_W-1:0]  wb_data,
    output logic               retire_ok,
    output logic               exc,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               resv_set
);

    lc_outcome_e oc;
    logic        kept_tag;

    always_comb begin
        oc       = OC_WRITE;
        kept_tag = 1'b0;
        if (mem_fault) begin
            oc = OC_MEM_FAULT;
        end else begin
            unique case (pol)
                POL_ALLOW: kept_tag = tag & perm_lc;
                POL_CLEAR: kept_tag = 1'b0;
                default: begin
                    if (tag) oc = OC_LC_FAULT;
                    kept_tag = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        wb_en     = 1'b0;
        wb_tag    = 1'b0;
        wb_data   = '0;
        retire_ok = 1'b0;
        exc       = 1'b0;
        exc_cause = '0;
        resv_set  = 1'b0;
        unique case (oc)
            OC_WRITE: begin
                wb_en     = 1'b1;
                wb_tag    = kept_tag;
                wb_data   = data;
                retire_ok = 1'b1;
                resv_set  = lr;
            end
            OC_LC_FAULT: begin
                exc       = 1'b1;
                exc_cause = LC_FAULT_CAUSE;
            end
            default: begin
                exc       = 1'b1;
                exc_cause = mem_cause;
            end
        endcase
    end

endmodule

// File: rtl/cap_ld_out_stage.sv
module cap_ld_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] q
);

    logic         full_q;
    logic [W-1:0] data_q;
    logic         take;

    assign in_ready = !full_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b1;
                data_q <= d;
            end else if (out_ready) begin
                full_q <= 1'b0;
            end
        end
    end

    assign out_valid = full_q;
    assign q         = data_q;

endmodule

// File: rtl/cap_load_tag_filter.sv
module cap_load_tag_filter
    import cap_ld_pkg::*;
#(
    parameter int                 LEVELS         = 3,
    parameter int                 DATA_W         = 64,
    parameter int                 CAUSE_W        = 6,
    parameter logic [CAUSE_W-1:0] LC_FAULT_CAUSE = CAUSE_W'(27)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_tag,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_perm_lc,
    input  logic                in_lr,
    input  logic                in_mem_fault,
    input  logic [CAUSE_W-1:0]  in_mem_cause,
    input  logic [2*LEVELS-1:0] in_lvl_pol,
    input  logic [LEVELS-1:0]   in_lvl_used,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_wb_en,
    output logic                out_wb_tag,
    output logic [DATA_W-1:0]   out_wb_data,
    output logic                out_retire_ok,
    output logic                out_exc,
    output logic [CAUSE_W-1:0]  out_exc_cause,
    output logic                out_resv_set
);

    localparam int RES_W = DATA_W + CAUSE_W + 5;

    lc_pol_e             pol;
    logic                d_wb_en, d_wb_tag, d_ok, d_exc, d_resv;
    logic [DATA_W-1:0]   d_wb_data;
    logic [CAUSE_W-1:0]  d_cause;
    logic [RES_W-1:0]    res_d, res_q;

    cap_ld_pol_fold #(.LEVELS(LEVELS)) u_fold (
        .lvl_pol  (in_lvl_pol),
        .lvl_used (in_lvl_used),
        .pol      (pol)
    );

    cap_ld_decide #(
        .DATA_W         (DATA_W),
        .CAUSE_W        (CAUSE_W),
        .LC_FAULT_CAUSE (LC_FAULT_CAUSE)
    ) u_decide (
        .tag       (in_tag),
        .data      (in_data),
        .perm_lc   (in_perm_lc),
        .lr        (in_lr),
        .mem_fault (in_mem_fault),
        .mem_cause (in_mem_cause),
        .pol       (pol),
        .wb_en     (d_wb_en),
        .wb_tag    (d_wb_tag),
        .wb_data   (d_wb_data),
        .retire_ok (d_ok),
        .exc       (d_exc),
        .exc_cause (d_cause),
        .resv_set  (d_resv)
    );

    assign res_d = {d_wb_en, d_wb_tag, d_wb_data, d_ok, d_exc, d_cause, d_resv};

    cap_ld_out_stage #(.W(RES_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (res_q)
    );

    assign {out_wb_en, out_wb_tag, out_wb_data, out_retire_ok,
            out_exc, out_exc_cause, out_resv_set} = res_q;

endmodule

// File: rtl/cap_load_tag_filter_chk.sv
module cap_load_tag_filter_chk #(
    parameter int DATA_W  = 64,
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_wb_en,
    input logic               out_wb_tag,
    input logic [DATA_W-1:0]  out_wb_data,
    input logic               out_retire_ok,
    input logic               out_exc,
    input logic [CAUSE_W-1:0] out_exc_cause,
    input logic               out_resv_set
);

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_wb_data)
            && $stable(out_wb_tag) && $stable(out_exc) && $stable(out_exc_cause)
            && $stable(out_retire_ok) && $stable(out_resv_set)));

    // R3 and R6: a raised exception never writes back and never retires.
    assert_exc_nowb_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exc) |-> (!out_wb_en && !out_retire_ok));

    assert_one_status_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_retire_ok != out_exc));

    assert_resv_ok_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_resv_set) |-> (out_retire_ok && !out_exc));

    assert_nowb_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wb_en) |-> (!out_wb_tag && out_wb_data == '0));

endmodule

bind cap_load_tag_filter cap_load_tag_filter_chk #(
    .DATA_W  (DATA_W),
    .CAUSE_W (CAUSE_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_wb_en     (out_wb_en),
    .out_wb_tag    (out_wb_tag),
    .out_wb_data   (out_wb_data),
    .out_retire_ok (out_retire_ok),
    .out_exc       (out_exc),
    .out_exc_cause (out_exc_cause),
    .out_resv_set  (out_resv_set)
);

// File: tb/cap_load_tag_filter_tb_top.sv
`timescale 1ns/1ps
module cap_load_tag_filter_tb_top;

    localparam int LEVELS  = 3;
    localparam int DATA_W  = 64;
    localparam int CAUSE_W = 6;
    localparam int LCF     = 27;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0, in_ready;
    logic                in_tag = 1'b0, in_perm_lc = 1'b0, in_lr = 1'b0, in_mem_fault = 1'b0;
    logic [DATA_W-1:0]   in_data = '0;
    logic [CAUSE_W-1:0]  in_mem_cause = '0;
    logic [2*LEVELS-1:0] in_lvl_pol = '0;
    logic [LEVELS-1:0]   in_lvl_used = '0;
    logic                out_valid, out_ready = 1'b1;
    logic                out_wb_en, out_wb_tag, out_retire_ok, out_exc, out_resv_set;
    logic [DATA_W-1:0]   out_wb_data;
    logic [CAUSE_W-1:0]  out_exc_cause;

    always #10 clk = ~clk;

    cap_load_tag_filter #(.LEVELS(LEVELS), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_data(in_data), .in_perm_lc(in_perm_lc), .in_lr(in_lr),
        .in_mem_fault(in_mem_fault), .in_mem_cause(in_mem_cause),
        .in_lvl_pol(in_lvl_pol), .in_lvl_used(in_lvl_used),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_wb_en(out_wb_en), .out_wb_tag(out_wb_tag), .out_wb_data(out_wb_data),
        .out_retire_ok(out_retire_ok), .out_exc(out_exc), .out_exc_cause(out_exc_cause),
        .out_resv_set(out_resv_set)
    );

    typedef struct {
        bit              wb_en;
        bit              tag;
        bit [DATA_W-1:0] data;
        bit              ok;
        bit              exc;
        int              cause;
        bit              resv;
        string           req;
    } exp_t;

    exp_t  expq[$];
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string label = "";

    // Behavioural model of one outcome, written from the requirements.
    function automatic exp_t model();
        exp_t e;
        int   acc, p;
        acc = 0;
        for (int i = 0; i < LEVELS; i++) begin
            if (in_lvl_used[i]) begin
                p = int'(in_lvl_pol[2*i +: 2]);
                if (p == 3) p = 2;       // R8
                if (p > acc) acc = p;    // R7
            end
        end
        e = '{0, 0, '0, 0, 0, 0, 0, ""};
        if (in_mem_fault) begin
            e.exc = 1; e.cause = int'(in_mem_cause); e.req = "R6";
        end else if (acc == 0) begin
            e.wb_en = 1; e.tag = in_tag & in_perm_lc; e.data = in_data; e.ok = 1;
            e.resv = in_lr; e.req = "R1";
        end else if (acc == 1) begin
            e.wb_en = 1; e.tag = 0; e.data = in_data; e.ok = 1; e.resv = in_lr; e.req = "R2";
        end else if (in_tag) begin
            e.exc = 1; e.cause = LCF; e.req = "R3";
        end else begin
            e.wb_en = 1; e.tag = 0; e.data = in_data; e.ok = 1; e.resv = in_lr; e.req = "R4";
        end
        if (label != "") e.req = label;
        return e;
    endfunction

    task automatic check_bit(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: inputs already placed by caller after the negedge.
    task automatic step();
        exp_t e;
        #1;
        check_bit("R9", "out_valid_vs_model", int'(out_valid), int'(expq.size() != 0));
        if (out_valid && expq.size() != 0 && out_ready) begin
            e = expq.pop_front();
            n_cmp++;
            if (out_wb_en != e.wb_en || out_wb_tag != e.tag || out_wb_data != e.data ||
                out_retire_ok != e.ok || out_exc != e.exc || int'(out_exc_cause) != e.cause ||
                out_resv_set != e.resv) begin
                n_bad++;
                $display("FAIL %s actual={wb=%0b tag=%0b data=%h ok=%0b exc=%0b cause=%0d resv=%0b} expected={wb=%0b tag=%0b data=%h ok=%0b exc=%0b cause=%0d resv=%0b}",
                    e.req, out_wb_en, out_wb_tag, out_wb_data, out_retire_ok, out_exc,
                    out_exc_cause, out_resv_set, e.wb_en, e.tag, e.data, e.ok, e.exc,
                    e.cause, e.resv);
            end
        end
        if (in_valid && in_ready) expq.push_back(model());
        @(negedge clk);
    endtask

    task automatic put(input string req, input bit tag, input bit perm, input bit lr,
                       input bit mf, input int mc, input bit [5:0] pol, input bit [2:0] used);
        label = req;
        in_valid = 1; in_tag = tag; in_perm_lc = perm; in_lr = lr; in_mem_fault = mf;
        in_mem_cause = CAUSE_W'(mc); in_lvl_pol = pol; in_lvl_used = used;
        in_data = {$urandom, $urandom};
        step();
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check_bit("R10", "out_valid_after_reset", int'(out_valid), 0);
        check_bit("R10", "in_ready_after_reset", int'(in_ready), 1);
        @(negedge clk);

        // R1: allow, tag gated by permission
        put("R1", 1, 1, 0, 0, 0, 6'b000000, 3'b111);
        put("R1", 1, 0, 0, 0, 0, 6'b000000, 3'b111);
        put("R1", 0, 1, 0, 0, 0, 6'b000000, 3'b001);
        // R2: clear
        put("R2", 1, 1, 0, 0, 0, 6'b000001, 3'b001);
        // R3: trap with tag
        put("R3", 1, 1, 1, 0, 0, 6'b000010, 3'b001);
        // R4: trap without tag
        put("R4", 0, 1, 0, 0, 0, 6'b100000, 3'b100);
        // R5: reservation on success paths only
        put("R5", 1, 1, 1, 0, 0, 6'b000000, 3'b001);
        put("R5", 1, 1, 1, 0, 0, 6'b000001, 3'b001);
        put("R5", 0, 1, 1, 0, 0, 6'b000010, 3'b001);
        put("R5", 1, 1, 1, 0, 0, 6'b000010, 3'b001);
        // R6: memory fault wins over allow and trap
        put("R6", 1, 1, 1, 1, 13, 6'b000000, 3'b001);
        put("R6", 1, 1, 0, 1, 5, 6'b000010, 3'b001);
        // R7: fold order, unused levels ignored, empty walk is allow
        put("R7", 1, 1, 0, 0, 0, 6'b011000, 3'b110);   // trap then clear -> trap
        put("R7", 1, 1, 0, 0, 0, 6'b000110, 3'b011);   // clear,trap -> trap
        put("R7", 1, 1, 0, 0, 0, 6'b000100, 3'b110);   // allow,clear -> clear
        put("R7", 1, 1, 0, 0, 0, 6'b101010, 3'b000);   // none used -> allow
        // R8: code 11 acts as trap
        put("R8", 1, 1, 0, 0, 0, 6'b001100, 3'b010);
        put("R8", 0, 1, 1, 0, 0, 6'b110000, 3'b100);
        // R11: no writeback means zero tag/data
        put("R11", 1, 1, 0, 0, 0, 6'b000010, 3'b001);
        idle(2);

        // R9: back-pressure with random traffic
        label = "";
        for (int c = 0; c < 3000; c++) begin
            in_valid     = ($urandom % 10) < 7;
            out_ready    = ($urandom % 10) < 6;
            in_tag       = $urandom % 2;
            in_perm_lc   = $urandom % 2;
            in_lr        = $urandom % 2;
            in_mem_fault = ($urandom % 8) == 0;
            in_mem_cause = CAUSE_W'($urandom);
            in_lvl_pol   = (2*LEVELS)'($urandom);
            in_lvl_used  = LEVELS'($urandom);
            in_data      = {$urandom, $urandom};
            step();
        end
        out_ready = 1;
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule